// File: doc/BRIEF.md
# Power-on serial PLL configuration loader

This block programs an external PLL synthesizer once after every reset. It drives a three-wire serial link (data, shift clock, latch strobe) and shifts out three 24-bit configuration words, most significant bit first, in a fixed order. The order is the initialization word, then the reference-divider word, then the feedback-divider word. Before each round of three words it lights a status LED for a long, visible interval. It repeats the whole round a set number of times. After that it raises a done flag and keeps every serial and LED output low until the next reset, so the link adds no switching noise once the PLL is running.

Every interval comes from a tick count that is derived from the system clock frequency parameter. The configuration words, the number of rounds, the settling interval and the LED interval are all parameters, so one block can serve PLLs with other divider settings.

Top module: `pll_cfg_loader`

## Requirements
- R1: Each configuration word is 24 bits long and goes out most significant bit first. Bit values are sampled on the rising edge of the shift clock.
- R2: For each bit, the data line is set first and then held steady for exactly one step (SETTLE_US microseconds) before the shift clock rises. The shift clock then stays high for exactly one step while the data line does not change.
- R3: After the 24th bit, the shift clock stays low for one further step. The latch strobe then goes high for exactly one step. The shift clock and the latch strobe are never high together.
- R4: The words of a round follow a fixed order: INIT_WORD (default 0x090093, low bits 11), then REF_WORD (default 0x1000A0, low bits 00), then FB_WORD (default 0x01A901, low bits 01).
- R5: Before each round, the LED output is high for exactly LED_US microseconds and then low. The serial outputs are all low while the LED is high.
- R6: The block runs PASSES rounds, which gives 3×PASSES latch strobes and PASSES LED pulses. It then goes idle with the data, shift clock, latch and LED outputs held low.
- R7: The done output rises in the cycle after the final latch strobe ends and stays high until the next reset.
- R8: While rst_n is low, all outputs are low. Asserting rst_n in the middle of a sequence aborts it, and release restarts from the first round and the first word.
- R9: One step is CLK_HZ/1e6 × SETTLE_US cycles. From reset release to done takes 1 + PASSES × (LED cycles + 3 × 50 steps) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ, at least 1 MHz |
| rst_n | input | 1 | Asynchronous active-low reset; release starts a sequence |
| ser_data | output | 1 | Serial data to the PLL |
| ser_clk | output | 1 | Serial shift clock |
| ser_latch | output | 1 | Load strobe that latches a complete word |
| led | output | 1 | Status LED, pulsed before each round |
| done | output | 1 | High once all rounds are complete |

## Verification
The bench decodes the serial waveform rather than predicting individual cycles. It reassembles each word from the shift-clock edges and measures every setup, clock-high, gap, strobe and LED width in cycles. A design that shifts least significant bit first, or that drops or adds a bit, produces a wrong word or a bit count other than 24 at the strobe. A setup interval that is too short, or a strobe that comes straight after the last clock pulse, shows up as a wrong measured width. The bench also checks the round count and the exact cycle on which done rises. A design with an off-by-one round count, or an LED pulse placed after the words, fails those checks. A further test resets the block in the middle of the second round and requires a full, correctly ordered restart with no leftover state.

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader #(
  parameter int unsigned CLK_HZ    = 10_000_000,
  parameter int unsigned SETTLE_US = 10,
  parameter int unsigned LED_US    = 100_000,
  parameter int unsigned PASSES    = 3,
  parameter logic [23:0] INIT_WORD = 24'h090093,
  parameter logic [23:0] REF_WORD  = 24'h1000A0,
  parameter logic [23:0] FB_WORD   = 24'h01A901
) (
  input  logic clk,
  input  logic rst_n,
  output logic ser_data,
  output logic ser_clk,
  output logic ser_latch,
  output logic led,
  output logic done
);
  localparam int unsigned TPU      = CLK_HZ / 1_000_000;
  localparam int unsigned STEP_CYC = TPU * SETTLE_US;
  localparam int unsigned LED_CYC  = TPU * LED_US;
  localparam int unsigned CMAX     = (LED_CYC > STEP_CYC) ? LED_CYC : STEP_CYC;
  localparam int unsigned CW       = $clog2(CMAX + 1);
  localparam int unsigned PW       = (PASSES > 1) ? $clog2(PASSES) : 1;

  typedef enum logic [2:0] {
    ST_BOOT, ST_LED, ST_SETUP, ST_HIGH, ST_GAP, ST_LATCH, ST_DONE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [4:0]    bidx;
  logic [1:0]    widx;
  logic [PW-1:0] pass;
  logic [23:0]   word;
  logic          cnt_end;

  assign word    = (widx == 2'd0) ? INIT_WORD : (widx == 2'd1) ? REF_WORD : FB_WORD;
  assign cnt_end = (st == ST_LED) ? (cnt == CW'(LED_CYC - 1)) : (cnt == CW'(STEP_CYC - 1));

  assign ser_data  = (st == ST_SETUP || st == ST_HIGH) && word[bidx];
  assign ser_clk   = (st == ST_HIGH);
  assign ser_latch = (st == ST_LATCH);
  assign led       = (st == ST_LED);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_BOOT;
      cnt  <= '0;
      bidx <= 5'd23;
      widx <= 2'd0;
      pass <= '0;
    end else if (st == ST_BOOT) begin
      st  <= ST_LED;
      cnt <= '0;
    end else if (st != ST_DONE) begin
      if (!cnt_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          ST_LED: begin
            st   <= ST_SETUP;
            bidx <= 5'd23;
            widx <= 2'd0;
          end
          ST_SETUP: st <= ST_HIGH;
          ST_HIGH: begin
            if (bidx == 5'd0) st <= ST_GAP;
            else begin
              bidx <= bidx - 1'b1;
              st   <= ST_SETUP;
            end
          end
          ST_GAP: st <= ST_LATCH;
          ST_LATCH: begin
            if (widx == 2'd2) begin
              if (pass == PW'(PASSES - 1)) st <= ST_DONE;
              else begin
                pass <= pass + 1'b1;
                st   <= ST_LED;
              end
            end else begin
              widx <= widx + 1'b1;
              bidx <= 5'd23;
              st   <= ST_SETUP;
            end
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pll_cfg_loader_chk.sv
module pll_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_latch,
  input logic led,
  input logic done
);
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data)); // R2
  AST_CLK_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && ser_latch)); // R3
  AST_LATCH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch) |-> !$past(ser_clk)); // R3
  AST_LED_SERIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> (!ser_clk && !ser_latch && !ser_data)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_clk && !ser_latch && !ser_data && !led)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R7
  AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ser_latch)); // R7
endmodule

bind pll_cfg_loader pll_cfg_loader_chk u_chk (.*);

// File: tb/sim_pll_cfg_loader.sv
module sim_pll_cfg_loader;
  localparam int CLK_NS = 10;
  localparam int unsigned TB_HZ = 1_000_000;
  localparam int unsigned TB_SETTLE = 10;
  localparam int unsigned TB_LED = 200;
  localparam int unsigned TB_PASSES = 3;
  localparam int STEP = TB_HZ / 1_000_000 * TB_SETTLE;
  localparam int LEDC = TB_HZ / 1_000_000 * TB_LED;
  localparam int TOTAL = 1 + TB_PASSES * (LEDC + 3 * 50 * STEP);

  logic clk = 0, rst_n = 0;
  logic ser_data, ser_clk, ser_latch, led, done;
  int tests = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  pll_cfg_loader #(.CLK_HZ(TB_HZ), .SETTLE_US(TB_SETTLE), .LED_US(TB_LED),
                   .PASSES(TB_PASSES)) u0 (.*);

  function automatic logic [23:0] exp_word(int i);
    case (i % 3)
      0: return 24'h090093;
      1: return 24'h1000A0;
      default: return 24'h01A901;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int lowcnt, hicnt, lecnt_w, ledw, nbits, le_cnt, led_cnt;
  logic [23:0] shreg;
  logic p_d, p_c, p_l, p_led;

  always @(negedge clk) begin
    if (!rst_n) begin
      lowcnt = 0; hicnt = 0; lecnt_w = 0; ledw = 0; nbits = 0;
      le_cnt = 0; led_cnt = 0; shreg = 0;
      p_d = 0; p_c = 0; p_l = 0; p_led = 0;
    end else begin
      if (ser_clk && !p_c) begin
        chk(lowcnt == STEP, "R2", "data setup cycles", lowcnt, STEP);
        shreg = {shreg[22:0], ser_data};
        nbits++;
      end
      if (!ser_clk && p_c) chk(hicnt == STEP, "R2", "clock high cycles", hicnt, STEP);
      if (ser_latch && !p_l) begin
        chk(lowcnt == STEP, "R3", "gap before latch", lowcnt, STEP);
        chk(nbits == 24, "R1", "bits per word", nbits, 24);
        chk(shreg == exp_word(le_cnt), "R4", "word value/order", shreg, exp_word(le_cnt));
        chk(led_cnt == le_cnt / 3 + 1, "R5", "LED pulses before word", led_cnt, le_cnt / 3 + 1);
        le_cnt++;
        nbits = 0;
      end
      if (!ser_latch && p_l) chk(lecnt_w == STEP, "R3", "latch width", lecnt_w, STEP);
      if (led && !p_led) begin
        chk(le_cnt == 3 * led_cnt, "R5", "LED leads round", le_cnt, 3 * led_cnt);
        led_cnt++;
      end
      if (!led && p_led) chk(ledw == LEDC, "R5", "LED width", ledw, LEDC);

      if (ser_clk || ser_latch || led) lowcnt = 0;
      else if (ser_data != p_d) lowcnt = 1;
      else lowcnt++;
      hicnt   = ser_clk ? hicnt + 1 : 0;
      lecnt_w = ser_latch ? lecnt_w + 1 : 0;
      ledw    = led ? ledw + 1 : 0;
      p_d = ser_data; p_c = ser_clk; p_l = ser_latch; p_led = led;
    end
  end

  task automatic run_to_done(string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n == TOTAL, "R9", {tag, " cycles to done"}, n, TOTAL);
    chk(le_cnt == 3 * TB_PASSES, "R6", {tag, " latch strobes"}, le_cnt, 3 * TB_PASSES);
    chk(led_cnt == TB_PASSES, "R6", {tag, " LED pulses"}, led_cnt, TB_PASSES);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk({ser_data, ser_clk, ser_latch, led, done} == 0, "R8", "outputs in reset",
        {ser_data, ser_clk, ser_latch, led, done}, 0);
    #1 rst_n = 1;
    run_to_done("first run");

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!done || ser_data || ser_clk || ser_latch || led) begin
        chk(0, "R7", "idle quiet/done held", {ser_data, ser_clk, ser_latch, led, done}, 1);
        break;
      end
    end
    chk(done, "R7", "done after idle window", done, 1);
    chk(le_cnt == 3 * TB_PASSES, "R6", "no strobes while idle", le_cnt, 3 * TB_PASSES);

    @(negedge clk); #1 rst_n = 0;
    @(negedge clk);
    chk(done == 0, "R8", "done cleared by reset", done, 0);
    #1 rst_n = 1;
    while (le_cnt < 4) @(negedge clk);
    repeat (37) @(negedge clk);
    #1 rst_n = 0;
    @(negedge clk);
    chk({ser_data, ser_clk, ser_latch, led, done} == 0, "R8", "outputs on abort",
        {ser_data, ser_clk, ser_latch, led, done}, 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    run_to_done("restart");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule